// File: doc/BRIEF.md
# Progress Semaphore Release Unit

This block finishes each unit of engine work by publishing a progress marker. When a release command is accepted it takes the next value of a monotonically increasing 32-bit progress counter, samples a free-running 64-bit cycle timer in the same clock edge, and issues both as a single 16-byte record to a sync location in host memory through a one-beat write request that is held until acknowledged. Only after the acknowledge does the block treat the new value as visible, update its committed progress value and, when the command asked for it, set a sticky completion interrupt.

A built-in wait comparator tells a consumer whether the committed progress value has reached a target. The test is "at or beyond", computed on the 32-bit difference as a signed number, so the counter may roll over without breaking waits. A waiter either polls the comparator or sleeps until the interrupt fires and then rechecks. Because the committed value moves only on acknowledge, a waiter can see an old value but never one that is ahead of memory.

Top module: `sync_release_unit`

## Requirements
- R1: After reset the committed progress value equals the parameter START_VALUE; every accepted release carries the previous value plus one, modulo 2^32, so rollover from 0xFFFFFFFF gives 0.
- R2: The write request carries the command's address and a 128-bit record with the progress value in bits [31:0], zero in bits [63:32] and the timestamp in bits [127:64]; address and record stay unchanged while the request waits for its acknowledge.
- R3: The timer is zero while reset is asserted and increments by one on every clock after; the timestamp in a record is the timer value present in the cycle the command is accepted.
- R4: The command ready output is high only when no write is outstanding: it drops in the cycle after acceptance, the request valid rises in that same cycle, and ready returns in the cycle after the acknowledge; a command held valid meanwhile is accepted once, afterwards.
- R5: The committed progress value changes only on the clock edge where the request is acknowledged; before that, a target equal to the in-flight value is reported as not reached.
- R6: The wait-met output is high exactly when (committed value minus target), taken as a signed 32-bit number, is zero or positive.
- R7: The interrupt-pending output rises in the cycle after an acknowledged write whose command had its interrupt-enable bit set, and not for a command with the bit clear.
- R8: A one-cycle pulse on the interrupt clear input lowers the pending flag; when a clear and a new set coincide, the flag stays set.
- R9: In reset, command ready is high, request valid and interrupt pending are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Release command offered |
| cmdReady | output | 1 | Release command can be taken |
| cmdAddr | input | ADDR_W (40) | Host address of the sync record |
| cmdIrqEn | input | 1 | Raise interrupt when this release completes |
| memReqValid | output | 1 | Write request outstanding |
| memReqAck | input | 1 | Write request accepted by memory |
| memReqAddr | output | ADDR_W (40) | Write address |
| memReqData | output | 128 | Record: value, reserved zero, timestamp |
| syncValue | output | 32 | Committed progress value |
| irqPending | output | 1 | Sticky completion interrupt |
| irqClear | input | 1 | Write-one-to-clear for the interrupt |
| waitTarget | input | 32 | Target value for the wait comparator |
| waitMet | output | 1 | Committed value is at or beyond the target |

## Verification
The bench starts the counter three steps below rollover, so a plain unsigned compare or a counter that saturates would flip the wait result on the targets that straddle zero. It asks whether the in-flight value is reached while the acknowledge is withheld for several cycles; a design that commits at issue would release the waiter early. A command is held valid across the busy window to catch a double acceptance, and a clear is pulsed on the same edge as a new interrupt to catch a clear that wins over the set. Timestamps are compared against a cycle count, which exposes a capture taken one edge late or at the acknowledge.

// File: rtl/sync_release_pkg.sv
package sync_release_pkg;

  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic capture;   // command accepted: latch value, timestamp, address
    logic commit;    // write acknowledged: publish value
    logic raiseIrq;  // commit of a release that asked for an interrupt
  } relStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } relState_t;

endpackage

// File: rtl/sync_release_ctrl.sv
module sync_release_ctrl
  import sync_release_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdIrqEn,
  input  logic       memReqAck,
  output logic       cmdReady,
  output logic       memReqValid,
  output relStrobe_t strobe
);

  relState_t state;
  logic      irqEnQ;

  always_comb begin
    cmdReady        = (state == ST_IDLE);
    memReqValid     = (state == ST_WRITE);
    strobe.capture  = cmdReady && cmdValid;
    strobe.commit   = memReqValid && memReqAck;
    strobe.raiseIrq = strobe.commit && irqEnQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      irqEnQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.capture) begin
          state  <= ST_WRITE;
          irqEnQ <= cmdIrqEn;
        end
        ST_WRITE: if (strobe.commit) begin
          state  <= ST_IDLE;
          irqEnQ <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sync_release_dp.sv
module sync_release_dp
  import sync_release_pkg::*;
#(
  parameter int          ADDR_W      = 40,
  parameter int          VAL_W       = 32,
  parameter int          TS_W        = 64,
  parameter logic [31:0] START_VALUE = '0,
  localparam int         REC_W       = 2 * VAL_W + TS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  relStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              irqClear,
  input  logic [VAL_W-1:0]  waitTarget,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [REC_W-1:0]  memReqData,
  output logic [VAL_W-1:0]  syncValue,
  output logic              irqPending,
  output logic              waitMet
);

  logic [TS_W-1:0]  timer;
  logic [TS_W-1:0]  tsQ;
  logic [VAL_W-1:0] issueVal;
  logic [ADDR_W-1:0] addrQ;
  logic [VAL_W-1:0] distance;

  // Free-running timestamp source.
  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else       timer <= timer + 1'b1;
  end

  // Value and timestamp are latched on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsQ      <= '0;
      issueVal <= START_VALUE[VAL_W-1:0];
      addrQ    <= '0;
    end else if (strobe.capture) begin
      tsQ      <= timer;
      issueVal <= syncValue + 1'b1;
      addrQ    <= cmdAddr;
    end
  end

  // Published value moves only once memory has taken the record.
  always_ff @(posedge clk) begin
    if (!rstN)              syncValue <= START_VALUE[VAL_W-1:0];
    else if (strobe.commit) syncValue <= issueVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                irqPending <= 1'b0;
    else if (strobe.raiseIrq) irqPending <= 1'b1;
    else if (irqClear)        irqPending <= 1'b0;
  end

  always_comb begin
    memReqAddr = addrQ;
    memReqData = {tsQ, {VAL_W{1'b0}}, issueVal};
    distance   = syncValue - waitTarget;
    waitMet    = ~distance[VAL_W-1];
  end

endmodule

// File: rtl/sync_release_unit.sv
module sync_release_unit
  import sync_release_pkg::*;
#(
  parameter int          ADDR_W      = 40,
  parameter logic [31:0] START_VALUE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdIrqEn,
  output logic              memReqValid,
  input  logic              memReqAck,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [127:0]      memReqData,
  output logic [31:0]       syncValue,
  output logic              irqPending,
  input  logic              irqClear,
  input  logic [31:0]       waitTarget,
  output logic              waitMet
);

  relStrobe_t strobe;

  sync_release_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdIrqEn    (cmdIrqEn),
    .memReqAck   (memReqAck),
    .cmdReady    (cmdReady),
    .memReqValid (memReqValid),
    .strobe      (strobe)
  );

  sync_release_dp #(
    .ADDR_W      (ADDR_W),
    .VAL_W       (32),
    .TS_W        (64),
    .START_VALUE (START_VALUE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdAddr    (cmdAddr),
    .irqClear   (irqClear),
    .waitTarget (waitTarget),
    .memReqAddr (memReqAddr),
    .memReqData (memReqData),
    .syncValue  (syncValue),
    .irqPending (irqPending),
    .waitMet    (waitMet)
  );

endmodule

// File: rtl/sync_release_chk.sv
module sync_release_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic              memReqValid,
  input logic              memReqAck,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [127:0]      memReqData,
  input logic [31:0]       syncValue,
  input logic              irqPending
);

  assert_issue_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (memReqValid && !cmdReady));

  assert_ready_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqAck) |=> (cmdReady && !memReqValid));

  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqAck) |=>
      (memReqValid && $stable(memReqData) && $stable(memReqAddr)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqData[63:32] == 32'h0));

  assert_value_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqAck) |=> (syncValue == $past(syncValue) + 32'd1));

  assert_no_early_publish_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && memReqAck) |=> $stable(syncValue));

  assert_irq_after_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(memReqValid && memReqAck));

endmodule

bind sync_release_unit sync_release_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .memReqValid (memReqValid),
  .memReqAck   (memReqAck),
  .memReqAddr  (memReqAddr),
  .memReqData  (memReqData),
  .syncValue   (syncValue),
  .irqPending  (irqPending)
);

// File: tb/sync_release_unit_tb.sv
module sync_release_unit_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 40;
  localparam logic [31:0] START      = 32'hFFFF_FFFD;

  typedef struct packed {
    logic        irqEn;
    logic [1:0]  delay;
    logic [31:0] target;
    logic        expMet;
  } vec_t;

  // Values issued in order: FFFFFFFE, FFFFFFFF, 0, 1, 2, 3
  localparam vec_t VEC [6] = '{
    '{1'b0, 2'd0, 32'hFFFF_FFFE, 1'b1},
    '{1'b1, 2'd2, 32'h0000_0000, 1'b0},
    '{1'b0, 2'd1, 32'hFFFF_FFF0, 1'b1},
    '{1'b1, 2'd3, 32'h0000_0001, 1'b1},
    '{1'b0, 2'd0, 32'h0000_0006, 1'b0},
    '{1'b1, 2'd1, 32'h0000_0002, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic              cmdIrqEn = 1'b0;
  logic              memReqValid;
  logic              memReqAck = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic [127:0]      memReqData;
  logic [31:0]       syncValue;
  logic              irqPending;
  logic              irqClear = 1'b0;
  logic [31:0]       waitTarget = '0;
  logic              waitMet;

  logic [63:0] cyc;
  logic [31:0] model;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else       cyc <= cyc + 64'd1;
  end

  sync_release_unit #(.ADDR_W(ADDR_W), .START_VALUE(START)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdIrqEn(cmdIrqEn), .memReqValid(memReqValid),
    .memReqAck(memReqAck), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .syncValue(syncValue), .irqPending(irqPending), .irqClear(irqClear),
    .waitTarget(waitTarget), .waitMet(waitMet)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doRelease(input logic [ADDR_W-1:0] a, input bit en, input int dly,
                           input logic [31:0] tgt, input bit expMet, input bit clrAtAck);
    logic [63:0]  expTs;
    logic [31:0]  expV;
    logic [127:0] firstData;
    @(negedge clk);
    check(cmdReady == 1'b1, "R4", "ready before command", cmdReady, 1);
    cmdAddr = a; cmdIrqEn = en; cmdValid = 1'b1;
    expTs = cyc; expV = model + 32'd1;
    @(negedge clk);
    cmdValid = 1'b0;
    check(memReqValid && !cmdReady, "R4", "busy after accept", {memReqValid, cmdReady}, 2'b10);
    check(memReqData[31:0] == expV, "R1", "issued value", memReqData[31:0], expV);
    check(memReqData[63:32] == 32'h0, "R2", "reserved word", memReqData[63:32], 0);
    check(memReqData[127:64] == expTs, "R3", "timestamp", memReqData[127:64], expTs);
    check(memReqAddr == a, "R2", "address", memReqAddr, a);
    firstData = memReqData;
    waitTarget = expV;
    #1;
    check(waitMet == 1'b0, "R5", "in-flight value not yet reached", waitMet, 0);
    check(syncValue == model, "R5", "value before ack", syncValue, model);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(memReqValid && memReqData == firstData, "R2", "request held", memReqData, firstData);
    end
    memReqAck = 1'b1; irqClear = clrAtAck;
    @(negedge clk);
    memReqAck = 1'b0; irqClear = 1'b0;
    model = expV;
    check(!memReqValid && cmdReady, "R4", "idle after ack", {memReqValid, cmdReady}, 2'b01);
    check(syncValue == expV, "R5", "value after ack", syncValue, expV);
    check(irqPending == en, clrAtAck ? "R8" : "R7", "interrupt after ack", irqPending, en);
    waitTarget = tgt;
    #1;
    check(waitMet == expMet, "R6", "wait compare", waitMet, expMet);
    if (irqPending) begin
      irqClear = 1'b1;
      @(negedge clk);
      irqClear = 1'b0;
      check(irqPending == 1'b0, "R8", "interrupt cleared", irqPending, 0);
    end
  endtask

  initial begin
    model = START;
    repeat (3) @(negedge clk);
    // R9 reset state, R1 start value
    check(cmdReady == 1'b1, "R9", "ready in reset", cmdReady, 1);
    check(memReqValid == 1'b0, "R9", "no request in reset", memReqValid, 0);
    check(irqPending == 1'b0, "R9", "no interrupt in reset", irqPending, 0);
    check(syncValue == START, "R1", "start value", syncValue, START);
    rstN = 1'b1;

    foreach (VEC[k]) begin
      doRelease(40'h12_3456_0000 + 40'(k * 16), VEC[k].irqEn, int'(VEC[k].delay),
                VEC[k].target, VEC[k].expMet, 1'b0);
    end

    // R4: command held valid while busy is taken once, then again after ack
    @(negedge clk);
    cmdValid = 1'b1; cmdIrqEn = 1'b0; cmdAddr = 40'hAB_0000_0000;
    @(negedge clk);
    repeat (2) begin
      @(negedge clk);
      check(!cmdReady && memReqData[31:0] == model + 32'd1, "R4", "no second accept while busy",
            memReqData[31:0], model + 32'd1);
    end
    memReqAck = 1'b1;
    @(negedge clk);
    memReqAck = 1'b0;
    check(cmdReady && syncValue == model + 32'd1, "R4", "first completes", syncValue, model + 32'd1);
    @(negedge clk);
    cmdValid = 1'b0;
    check(memReqValid && memReqData[31:0] == model + 32'd2, "R4", "held command accepted once more",
          memReqData[31:0], model + 32'd2);
    memReqAck = 1'b1;
    @(negedge clk);
    memReqAck = 1'b0;
    model = model + 32'd2;
    check(syncValue == model, "R1", "value after back-to-back", syncValue, model);

    // R8: clear coinciding with a set leaves the flag set
    doRelease(40'h00_0000_1000, 1'b1, 1, model + 32'd1, 1'b1, 1'b1);

    // R6: target far ahead of value and exactly at value
    waitTarget = model + 32'h7FFF_FFFF;
    #1 check(waitMet == 1'b0, "R6", "far ahead target", waitMet, 0);
    waitTarget = model;
    #1 check(waitMet == 1'b1, "R6", "equal target", waitMet, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule